// File: doc/BRIEF.md
# Atomic-Update General-Purpose Output Port

This block is the register front end of one 16-pin general-purpose output port. It keeps the output data word, drives the pin outputs straight from that register, and returns the state of the pin inputs through a two-flop synchronizer. Software can change output pins without reading the port first. A dedicated set, clear or toggle address changes only the bits written as one. A combined word sets pins from its lower half and clears pins from its upper half in the same write. A write of ones to the pin-input address toggles the matching outputs.

The bus is a plain synchronous register bus. It has an access strobe, a write flag, a byte address, 32-bit write data and four byte strobes, so 8-, 16- and 32-bit accesses are all possible. Read data is registered and appears one cycle after the read request. Word offsets: 0x00 output data, 0x04 pin input, 0x08 combined set/clear, 0x0C set, 0x10 clear, 0x14 toggle.

Top module: `gpio_atomic_port`

## Requirements
- R1: While `rst` is high at a clock edge, the output register, `pin_out` and `rd_data` go to all zeros.
- R2: A write to 0x00 replaces the output bits in the enabled byte lanes and keeps the others. Bits 31:16 of that address are ignored and read back as zero. The new value is on `pin_out` right after the clock edge that samples the write.
- R3: A write to 0x0C sets each output bit whose written bit is one and leaves every other bit unchanged.
- R4: A write to 0x10 clears each output bit whose written bit is one and leaves every other bit unchanged.
- R5: A write to 0x14 inverts each output bit whose written bit is one and leaves every other bit unchanged.
- R6: A write to 0x08 sets outputs for ones in bits 15:0 and clears outputs for ones in bits 31:16, both in the same cycle. Zero bits have no effect.
- R7: If bit n and bit n+16 are both one in a write to 0x08, output n ends up set.
- R8: Byte strobe k gates data bits 8k+7..8k at every address. At 0x08, strobes 2 and 3 gate the clear half.
- R9: A write to the pin-input address 0x04 inverts each output bit whose written bit is one.
- R10: A read of 0x04 returns in bits 15:0 the `pin_in` value that has passed through two register stages, and zeros in bits 31:16.
- R11: Reads of 0x08, 0x0C, 0x10, 0x14, of unmapped addresses and of addresses that are not word aligned return zero. Writes to unmapped or unaligned addresses leave the outputs unchanged.
- R12: `rd_data` changes only after the clock edge that samples a read, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, one per lane |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin input levels |
| pin_out | output | 16 | Output pin levels, straight from the output register |

## Verification
The embedded assertions check on every cycle the local update rules. After a set, clear or toggle operation, the output register matches the operation applied to the previous value. After the combined word, set bits win. With no write the outputs hold still, and the upper half of the read data is always zero. The bench scenarios are the only place where address decoding, byte-lane gating at each address, the zero readback of write-only and unmapped locations, the one-cycle read latency and the two-stage delay of the input readback become visible.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_DATA,
    OP_BSR,
    OP_SET,
    OP_CLR,
    OP_TGL
  } gpio_op_t;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_DATA,
    RD_PINS
  } gpio_rsel_t;

  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_PINS = 1;
  localparam int unsigned IDX_BSR  = 2;
  localparam int unsigned IDX_SET  = 3;
  localparam int unsigned IDX_CLR  = 4;
  localparam int unsigned IDX_TGL  = 5;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW/8-1:0] bus_be,
  output gpio_op_t      wr_op,
  output gpio_rsel_t    rd_sel,
  output logic          rd_en,
  output logic [DW-1:0] lane_mask
);
  localparam int LANES = DW / 8;
  localparam int IW    = AW - 2;

  logic          aligned;
  logic [IW-1:0] widx;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[AW-1:2];
  assign rd_en   = bus_en && !bus_we;

  // expand byte strobes into a bit mask
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = {8{bus_be[k]}};
  end

  always_comb begin
    wr_op = OP_NONE;
    if (bus_en && bus_we && aligned) begin
      case (widx)
        IW'(IDX_DATA): wr_op = OP_DATA;
        IW'(IDX_PINS): wr_op = OP_TGL;
        IW'(IDX_BSR):  wr_op = OP_BSR;
        IW'(IDX_SET):  wr_op = OP_SET;
        IW'(IDX_CLR):  wr_op = OP_CLR;
        IW'(IDX_TGL):  wr_op = OP_TGL;
        default:       wr_op = OP_NONE;
      endcase
    end
  end

  always_comb begin
    rd_sel = RD_ZERO;
    if (aligned) begin
      if (widx == IW'(IDX_DATA)) rd_sel = RD_DATA;
      else if (widx == IW'(IDX_PINS)) rd_sel = RD_PINS;
    end
  end

  // R11: no write op is decoded for a misaligned address
  always_comb begin
    a_unaligned_r11 : assert (aligned || !bus_en || wr_op == OP_NONE);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);
  logic [NPINS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  gpio_op_t         op,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    lane_mask,
  output logic [NPINS-1:0] odr_q
);
  localparam int HALF = DW / 2;

  logic [NPINS-1:0] lo_bits;
  logic [NPINS-1:0] hi_bits;
  logic [NPINS-1:0] odr_d;

  assign lo_bits = wdata[NPINS-1:0] & lane_mask[NPINS-1:0];
  assign hi_bits = wdata[HALF+NPINS-1:HALF] & lane_mask[HALF+NPINS-1:HALF];

  always_comb begin
    odr_d = odr_q;
    case (op)
      OP_DATA: odr_d = (odr_q & ~lane_mask[NPINS-1:0]) | lo_bits;
      OP_BSR:  odr_d = (odr_q & ~hi_bits) | lo_bits;
      OP_SET:  odr_d = odr_q | lo_bits;
      OP_CLR:  odr_d = odr_q & ~lo_bits;
      OP_TGL:  odr_d = odr_q ^ lo_bits;
      default: odr_d = odr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) odr_q <= '0;
    else     odr_q <= odr_d;
  end

  p_set_r3 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_SET) |-> ((odr_q & $past(lo_bits)) == $past(lo_bits)));

  p_clr_r4 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_CLR) |-> ((odr_q & $past(lo_bits)) == '0));

  p_tgl_r5 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_TGL) |-> (odr_q == ($past(odr_q) ^ $past(lo_bits))));

  p_bsr_keep_r6 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_BSR) |->
      (((odr_q ^ $past(odr_q)) & ~($past(lo_bits) | $past(hi_bits))) == '0));

  p_bsr_prio_r7 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_BSR) |-> ((odr_q & $past(lo_bits)) == $past(lo_bits)));

  p_idle_hold_r11 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_NONE) |-> $stable(odr_q));
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
  import gpio_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int AW          = 5,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [DW/8-1:0]  bus_be,
  output logic [DW-1:0]    rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out
);
  gpio_op_t         wr_op;
  gpio_rsel_t       rd_sel;
  logic             rd_en;
  logic [DW-1:0]    lane_mask;
  logic [NPINS-1:0] odr_q;
  logic [NPINS-1:0] pins_sync;

  gpio_bus_decode #(.AW(AW), .DW(DW)) u_dec (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .wr_op    (wr_op),
    .rd_sel   (rd_sel),
    .rd_en    (rd_en),
    .lane_mask(lane_mask)
  );

  gpio_out_reg #(.NPINS(NPINS), .DW(DW)) u_odr (
    .clk      (clk),
    .rst      (rst),
    .op       (wr_op),
    .wdata    (bus_wdata),
    .lane_mask(lane_mask),
    .odr_q    (odr_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(pin_in),
    .sync_out(pins_sync)
  );

  assign pin_out = odr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_sel)
        RD_DATA: rd_data <= DW'(odr_q);
        RD_PINS: rd_data <= DW'(pins_sync);
        default: rd_data <= '0;
      endcase
    end
  end

  p_hi_zero_r10 : assert property (@(posedge clk) disable iff (rst)
    rd_data[DW-1:NPINS] == '0);

  p_rd_hold_r12 : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

// File: tb/sim_gpio_atomic_port.sv
module sim_gpio_atomic_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] rd_data;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] model = '0;
  logic [31:0] rv;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_atomic_port u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_be = 4'hF;
    @(negedge clk);
    bus_en = 0;
    d = rd_data;
  endtask

  function automatic logic [15:0] lm(logic [3:0] be, bit hi);
    return hi ? {{8{be[3]}}, {8{be[2]}}} : {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic t_reset;
    chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
  endtask

  task automatic t_data;
    wr(5'h00, 32'hFFFF_A5C3, 4'hF);
    model = 16'hA5C3;
    chk("R2 pin_out next cycle", {16'h0, pin_out}, {16'h0, model});
    rd(5'h00, rv);
    chk("R2 readback upper zero", rv, {16'h0, model});
    wr(5'h00, 32'h0000_3C00, 4'b0010);
    model = {8'h3C, model[7:0]};
    chk("R2/R8 byte lane", {16'h0, pin_out}, {16'h0, model});
  endtask

  task automatic t_set_clr_tgl;
    wr(5'h0C, 32'h0000_0F0F, 4'hF);
    model = model | 16'h0F0F;
    chk("R3 set", {16'h0, pin_out}, {16'h0, model});
    wr(5'h10, 32'h0000_3301, 4'hF);
    model = model & ~16'h3301;
    chk("R4 clear", {16'h0, pin_out}, {16'h0, model});
    wr(5'h14, 32'h0000_8421, 4'hF);
    model = model ^ 16'h8421;
    chk("R5 toggle", {16'h0, pin_out}, {16'h0, model});
    wr(5'h14, 32'h0000_FFFF, 4'b0001);
    model = model ^ 16'h00FF;
    chk("R5/R8 toggle low lane", {16'h0, pin_out}, {16'h0, model});
  endtask

  task automatic t_bsr;
    wr(5'h00, 32'h0000_00F0, 4'hF);
    model = 16'h00F0;
    wr(5'h08, 32'h00F0_0F00, 4'hF);
    model = (model & ~16'h00F0) | 16'h0F00;
    chk("R6 set+clear one write", {16'h0, pin_out}, {16'h0, model});
    wr(5'h08, 32'h0101_0101, 4'hF);
    model = model | 16'h0101;
    chk("R7 set wins", {16'h0, pin_out}, {16'h0, model});
    wr(5'h08, 32'hFFFF_FFFF, 4'b1100);
    model = model & ~lm(4'b1100, 1);
    chk("R8 upper lanes clear only", {16'h0, pin_out}, {16'h0, model});
    wr(5'h08, 32'hFFFF_00FF, 4'b0001);
    model = model | 16'h00FF;
    chk("R8 low lane set only", {16'h0, pin_out}, {16'h0, model});
  endtask

  task automatic t_pin_toggle;
    wr(5'h04, 32'h0000_F00F, 4'hF);
    model = model ^ 16'hF00F;
    chk("R9 pin addr toggles", {16'h0, pin_out}, {16'h0, model});
  endtask

  task automatic t_sync;
    @(negedge clk); pin_in = 16'hBEEF;
    rd(5'h04, rv);
    chk("R10 one stage not yet", rv, 32'h0);
    @(negedge clk);
    rd(5'h04, rv);
    chk("R10 synced value", rv, 32'h0000_BEEF);
  endtask

  task automatic t_zero_reads;
    foreach (rv[i]) if (i < 4) begin
      logic [31:0] d;
      rd(5'(8 + 4*i), d);
      chk("R11 write-only reads zero", d, 32'h0);
    end
    rd(5'h18, rv);
    chk("R11 unmapped reads zero", rv, 32'h0);
    rd(5'h01, rv);
    chk("R11 unaligned reads zero", rv, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF, 4'hF);
    chk("R11 unmapped write ignored", {16'h0, pin_out}, {16'h0, model});
    wr(5'h0D, 32'hFFFF_FFFF, 4'hF);
    chk("R11 unaligned write ignored", {16'h0, pin_out}, {16'h0, model});
  endtask

  task automatic t_latency;
    logic [31:0] held;
    rd(5'h00, held);
    chk("R12 read data", held, {16'h0, model});
    wr(5'h00, 32'h0000_1234, 4'hF);
    model = 16'h1234;
    chk("R12 holds across write", rd_data, held);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 5'h00;
    chk("R12 not before edge", rd_data, held);
    @(negedge clk); bus_en = 0;
    chk("R12 after edge", rd_data, {16'h0, model});
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model = '0;
    chk("R1 reset clears outputs", {16'h0, pin_out}, 32'h0);
    chk("R1 reset clears rd_data", rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_data;
    t_set_clr_tgl;
    t_bsr;
    t_pin_toggle;
    t_sync;
    t_zero_reads;
    t_latency;
    t_reset_again;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule